// File: doc/BRIEF.md
# SONET Transport Overhead Insertion Multiplexer

This block sits in the transmit path of a byte-interleaved STS-N stream (STS-12 by default) and rewrites the transport overhead (TOH) bytes as they pass. Payload bytes are never touched. For every TOH byte it picks one of three sources:
- the byte on the parallel input,
- a byte taken earlier from a bit-serial overhead port,
- a fixed or cleared local value.

Which source applies depends on the byte's type. A few types are fixed. The rest belong to four groups, and each group has its own insert/transparent control bit.

Position is tracked from a frame-start pulse that comes with the first framing byte. The tracker is a three-state machine:
- `TRK_UNSYNC`: no frame seen since reset.
- `TRK_OVERHEAD`: the current byte is in the first `3*NUM_STS` bytes of a row.
- `TRK_PAYLOAD`: the rest of the row.

Its transitions are:
- UNSYNC→OVERHEAD on frame start.
- OVERHEAD→PAYLOAD after the last TOH byte of a row.
- PAYLOAD→OVERHEAD at the start of each row.
- Any state→OVERHEAD on a frame start, which resynchronises the count.

The serial receiver is a second machine:
- `RX_HUNT` waits for the first serial frame start.
- `RX_BITS` shifts in bits, most significant first, and writes each completed byte into an overhead buffer.
- `RX_DONE` is entered after the last bit of a complete frame.

Its transitions are:
- HUNT→BITS on a serial frame start.
- BITS→DONE after the final bit.
- DONE→BITS on the next frame start. This edge is the only one that compares parity.
- BITS→BITS (restart) when a frame start arrives early.

Top module: `toh_insert_mux`

## Requirements
- R1: A cycle with `frame_start` high carries row 0, byte 0 of a frame. Following bytes are counted in interleaved order: STS index fastest, then column group (3 overhead groups followed by `PAYLOAD_COLS` payload groups), then row (9 rows). A new `frame_start` restarts the count from any position.
- R2: Framing bytes are always replaced: row 0 group 0 (A1) is output as 0xF6 and row 0 group 1 (A2) as 0x28, for every STS.
- R3: Row 1 group 0 (B1) is output as 0x00 for every STS. `b1_recalc` is high only for the STS index 0 B1 slot, and only together with that slot's output byte.
- R4: Row 0 group 2 (J0), all of row 3 (H1-H3) and row 4 group 0 (B2) pass the parallel byte unchanged, whatever the control bits are.
- R5: Group select bits in `cfg_insert`, where 1 means insert from the serial buffer and 0 means pass the parallel byte:
  - bit 0 covers K1/K2 (row 4 groups 1,2);
  - bit 1 covers S1/M0 (row 8 groups 0,1);
  - bit 2 covers E1/F1/E2 (row 1 groups 1,2 and row 8 group 2);
  - bit 3 covers D1-D12 (rows 2, 5, 6, 7, all groups).
- R6: Payload bytes (group 3 and above) are output equal to the parallel input.
- R7: The serial port delivers one bit per clock, most significant bit first, with `toh_sfs` high on the first bit of a frame. Bytes arrive in TOH scan order (row, then group, then STS). An inserted byte is the last serial byte received for its own scan position.
- R8: The first bit of each serial frame carries even parity over every bit of the previous frame, except that frame's own first bit. On a mismatch, `parity_error` is high for exactly one cycle, the cycle after the first bit is sampled.
- R9: No parity comparison is made when no complete serial frame precedes the frame start, either because none was received since reset or because the previous frame was cut short by an early `toh_sfs`.
- R10: `cfg_insert` is sampled only in the `frame_start` cycle and governs the whole frame. A change later in the frame has no effect until the next frame.
- R11: Before the first `frame_start` after reset, every byte passes unchanged and `b1_recalc` stays low.
- R12: Output latency is one clock. In reset, `pdata_out`, `b1_recalc` and `parity_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | High with the first A1 byte of a frame |
| pdata_in | input | 8 | Parallel stream byte |
| cfg_insert | input | 4 | Per-group insert select (K, S, E, D) |
| toh_sdi | input | 1 | Serial overhead data bit |
| toh_sfs | input | 1 | High with the first bit of a serial overhead frame |
| pdata_out | output | 8 | Stream byte after overhead selection |
| b1_recalc | output | 1 | Marks the B1 slot to be recomputed downstream |
| parity_error | output | 1 | One-cycle pulse on serial parity mismatch |

## Verification
The bench builds the block with `NUM_STS = 3` and `PAYLOAD_COLS = 4`. With these values a row is 21 bytes, a frame is 189 cycles and a serial overhead frame is 81 bytes. Many complete frames and serial parity cycles therefore fit in a short run, and several STS copies are still interleaved. This keeps the zero-filled B1 slots beyond STS index 0 in view, along with group selection on every copy, mid-frame control changes, early resynchronisation and truncated serial frames.

// File: rtl/toh_pkg.sv
package toh_pkg;

    typedef enum logic [2:0] {
        BK_A1,
        BK_A2,
        BK_PASS,
        BK_B1,
        BK_GK,
        BK_GS,
        BK_GE,
        BK_GD
    } byte_kind_e;

    localparam logic [7:0] A1_PATTERN = 8'hF6;
    localparam logic [7:0] A2_PATTERN = 8'h28;

    localparam int SEL_K = 0;
    localparam int SEL_S = 1;
    localparam int SEL_E = 2;
    localparam int SEL_D = 3;

    localparam int ROWS      = 9;
    localparam int OVH_GRPS  = 3;

    function automatic byte_kind_e classify(input logic [3:0] row, input logic [1:0] col);
        byte_kind_e k;
        k = BK_PASS;
        case (row)
            4'd0: k = (col == 2'd0) ? BK_A1 : ((col == 2'd1) ? BK_A2 : BK_PASS);
            4'd1: k = (col == 2'd0) ? BK_B1 : BK_GE;
            4'd2, 4'd5, 4'd6, 4'd7: k = BK_GD;
            4'd4: k = (col == 2'd0) ? BK_PASS : BK_GK;
            4'd8: k = (col == 2'd2) ? BK_GE : BK_GS;
            default: k = BK_PASS;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/toh_pos_tracker.sv
module toh_pos_tracker #(
    parameter int NUM_STS      = 12,
    parameter int PAYLOAD_COLS = 87,
    parameter int STS_W        = 4,
    parameter int IDX_W        = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    output logic             synced,
    output logic             is_toh,
    output logic [3:0]       row,
    output logic [1:0]       col,
    output logic             first_sts,
    output logic [IDX_W-1:0] toh_idx
);
    import toh_pkg::*;

    localparam int GRPS  = OVH_GRPS + PAYLOAD_COLS;
    localparam int GRP_W = $clog2(GRPS);

    typedef enum logic [1:0] {TRK_UNSYNC, TRK_OVERHEAD, TRK_PAYLOAD} trk_state_e;

    trk_state_e       state_q, state_d, cur_reg;
    logic [3:0]       row_q, cur_row, nx_row;
    logic [GRP_W-1:0] grp_q, cur_grp, nx_grp;
    logic [STS_W-1:0] sts_q, cur_sts, nx_sts;
    logic [IDX_W-1:0] idx_q, cur_idx, nx_idx;
    logic             wrap;

    // position of the byte presented this cycle, and of the one after it
    always_comb begin
        if (frame_start) begin
            cur_reg = TRK_OVERHEAD;
            cur_row = '0;
            cur_grp = '0;
            cur_sts = '0;
            cur_idx = '0;
        end else begin
            cur_reg = state_q;
            cur_row = row_q;
            cur_grp = grp_q;
            cur_sts = sts_q;
            cur_idx = idx_q;
        end

        nx_sts = cur_sts;
        nx_grp = cur_grp;
        nx_row = cur_row;
        if (cur_sts == STS_W'(NUM_STS - 1)) begin
            nx_sts = '0;
            if (cur_grp == GRP_W'(GRPS - 1)) begin
                nx_grp = '0;
                nx_row = (cur_row == 4'(ROWS - 1)) ? 4'd0 : cur_row + 4'd1;
            end else begin
                nx_grp = cur_grp + GRP_W'(1);
            end
        end else begin
            nx_sts = cur_sts + STS_W'(1);
        end

        wrap   = (nx_row == 4'd0) && (nx_grp == '0) && (nx_sts == '0);
        nx_idx = wrap ? '0 : ((cur_reg == TRK_OVERHEAD) ? cur_idx + IDX_W'(1) : cur_idx);

        unique case (cur_reg)
            TRK_UNSYNC:   state_d = TRK_UNSYNC;
            TRK_OVERHEAD,
            TRK_PAYLOAD:  state_d = (nx_grp < GRP_W'(OVH_GRPS)) ? TRK_OVERHEAD : TRK_PAYLOAD;
            default:      state_d = TRK_UNSYNC;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRK_UNSYNC;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            grp_q <= '0;
            sts_q <= '0;
            idx_q <= '0;
        end else begin
            row_q <= nx_row;
            grp_q <= nx_grp;
            sts_q <= nx_sts;
            idx_q <= nx_idx;
        end
    end

    // outputs
    always_comb begin
        synced    = (cur_reg != TRK_UNSYNC);
        is_toh    = (cur_reg == TRK_OVERHEAD);
        row       = cur_row;
        col       = cur_grp[1:0];
        first_sts = (cur_sts == '0);
        toh_idx   = cur_idx;
    end

    assert_sync_enters_overhead_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (state_q == TRK_OVERHEAD));

    assert_idx_after_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (idx_q == IDX_W'(1)));

    assert_unsync_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_UNSYNC && !frame_start) |=> (state_q == TRK_UNSYNC));

endmodule

// File: rtl/toh_serial_rx.sv
module toh_serial_rx #(
    parameter int TOH_BYTES = 324,
    parameter int IDX_W     = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sfs,
    input  logic             sdi,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             parity_error
);
    typedef enum logic [1:0] {RX_HUNT, RX_BITS, RX_DONE} rx_state_e;

    rx_state_e        state_q, state_d;
    logic [2:0]       bit_q, bit_d;
    logic [IDX_W-1:0] byte_q, byte_d;
    logic [6:0]       shift_q, shift_d;
    logic             acc_q, acc_d;
    logic             err_q, err_d;
    logic             byte_end;

    always_comb begin
        byte_end = (state_q == RX_BITS) && !sfs && (bit_q == 3'd7);
        state_d  = state_q;
        bit_d    = bit_q;
        byte_d   = byte_q;
        shift_d  = shift_q;
        acc_d    = acc_q;
        err_d    = 1'b0;
        if (sfs) begin
            // first bit is the parity of the previous frame and is not covered
            err_d   = (state_q == RX_DONE) && (sdi != acc_q);
            state_d = RX_BITS;
            bit_d   = 3'd1;
            byte_d  = '0;
            shift_d = {6'b0, sdi};
            acc_d   = 1'b0;
        end else begin
            unique case (state_q)
                RX_HUNT, RX_DONE: ;
                RX_BITS: begin
                    shift_d = {shift_q[5:0], sdi};
                    acc_d   = acc_q ^ sdi;
                    bit_d   = bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        if (byte_q == IDX_W'(TOH_BYTES - 1)) state_d = RX_DONE;
                        else                                  byte_d  = byte_q + IDX_W'(1);
                    end
                end
                default: state_d = RX_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q   <= '0;
            byte_q  <= '0;
            shift_q <= '0;
            acc_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            bit_q   <= bit_d;
            byte_q  <= byte_d;
            shift_q <= shift_d;
            acc_q   <= acc_d;
            err_q   <= err_d;
        end
    end

    // outputs
    always_comb begin
        wr_en        = byte_end;
        wr_addr      = byte_q;
        wr_data      = {shift_q, sdi};
        parity_error = err_q;
    end

    assert_err_follows_sfs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $past(sfs));

    assert_err_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !err_q);

    assert_no_check_incomplete_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sfs && state_q != RX_DONE) |=> !err_q);

endmodule

// File: rtl/toh_ovh_buffer.sv
module toh_ovh_buffer #(
    parameter int DEPTH = 324,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/toh_src_mux.sv
module toh_src_mux (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic [3:0] cfg_insert,
    input  logic       synced,
    input  logic       is_toh,
    input  logic [3:0] row,
    input  logic [1:0] col,
    input  logic       first_sts,
    input  logic [7:0] rd_data,
    input  logic [7:0] pdata_in,
    output logic [7:0] pdata_out,
    output logic       b1_recalc
);
    import toh_pkg::*;

    logic [3:0] cfg_q, cfg_now;
    logic [7:0] byte_d;
    logic       mark_d;
    byte_kind_e kind;

    always_comb begin
        cfg_now = frame_start ? cfg_insert : cfg_q;
        kind    = classify(row, col);
        byte_d  = pdata_in;
        mark_d  = 1'b0;
        if (synced && is_toh) begin
            unique case (kind)
                BK_A1:   byte_d = A1_PATTERN;
                BK_A2:   byte_d = A2_PATTERN;
                BK_PASS: byte_d = pdata_in;
                BK_B1: begin
                    byte_d = 8'h00;
                    mark_d = first_sts;
                end
                BK_GK:   byte_d = cfg_now[SEL_K] ? rd_data : pdata_in;
                BK_GS:   byte_d = cfg_now[SEL_S] ? rd_data : pdata_in;
                BK_GE:   byte_d = cfg_now[SEL_E] ? rd_data : pdata_in;
                BK_GD:   byte_d = cfg_now[SEL_D] ? rd_data : pdata_in;
                default: byte_d = pdata_in;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            pdata_out <= '0;
            b1_recalc <= 1'b0;
        end else begin
            cfg_q     <= cfg_now;
            pdata_out <= byte_d;
            b1_recalc <= mark_d;
        end
    end

    assert_cfg_frame_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(cfg_q));

    assert_unsync_passthrough_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |=> (pdata_out == $past(pdata_in) && !b1_recalc));

    assert_b1_slot_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        b1_recalc |-> (pdata_out == 8'h00));

endmodule

// File: rtl/toh_insert_mux.sv
module toh_insert_mux #(
    parameter int NUM_STS      = 12,
    parameter int PAYLOAD_COLS = 87
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic [7:0] pdata_in,
    input  logic [3:0] cfg_insert,
    input  logic       toh_sdi,
    input  logic       toh_sfs,
    output logic [7:0] pdata_out,
    output logic       b1_recalc,
    output logic       parity_error
);
    localparam int TOH_BYTES = 27 * NUM_STS;
    localparam int IDX_W     = $clog2(TOH_BYTES + 1);
    localparam int STS_W     = (NUM_STS > 1) ? $clog2(NUM_STS) : 1;

    logic             synced, is_toh, first_sts;
    logic [3:0]       row;
    logic [1:0]       col;
    logic [IDX_W-1:0] toh_idx, wr_addr;
    logic             wr_en;
    logic [7:0]       wr_data, rd_data;

    toh_pos_tracker #(
        .NUM_STS      (NUM_STS),
        .PAYLOAD_COLS (PAYLOAD_COLS),
        .STS_W        (STS_W),
        .IDX_W        (IDX_W)
    ) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .synced      (synced),
        .is_toh      (is_toh),
        .row         (row),
        .col         (col),
        .first_sts   (first_sts),
        .toh_idx     (toh_idx)
    );

    toh_serial_rx #(
        .TOH_BYTES (TOH_BYTES),
        .IDX_W     (IDX_W)
    ) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .sfs          (toh_sfs),
        .sdi          (toh_sdi),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .parity_error (parity_error)
    );

    toh_ovh_buffer #(
        .DEPTH (TOH_BYTES),
        .AW    (IDX_W)
    ) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (toh_idx),
        .rd_data (rd_data)
    );

    toh_src_mux u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .cfg_insert  (cfg_insert),
        .synced      (synced),
        .is_toh      (is_toh),
        .row         (row),
        .col         (col),
        .first_sts   (first_sts),
        .rd_data     (rd_data),
        .pdata_in    (pdata_in),
        .pdata_out   (pdata_out),
        .b1_recalc   (b1_recalc)
    );

    assert_framing_after_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (pdata_out == 8'hF6 && !b1_recalc));

endmodule

// File: tb/sim_toh_insert_mux.sv
`timescale 1ns/1ps
module sim_toh_insert_mux;
    localparam int NS   = 3;
    localparam int PC   = 4;
    localparam int GRPS = 3 + PC;
    localparam int TOHB = 27 * NS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic [7:0] pdata_in = '0;
    logic [3:0] cfg_insert = '0;
    logic       toh_sdi = 1'b0;
    logic       toh_sfs = 1'b0;
    logic [7:0] pdata_out;
    logic       b1_recalc;
    logic       parity_error;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [7:0] sb [TOHB];
    bit pv_valid = 1'b0;
    bit pv_par   = 1'b0;

    always #2.5 clk = ~clk;

    toh_insert_mux #(.NUM_STS(NS), .PAYLOAD_COLS(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pdata_in(pdata_in),
        .cfg_insert(cfg_insert), .toh_sdi(toh_sdi), .toh_sfs(toh_sfs),
        .pdata_out(pdata_out), .b1_recalc(b1_recalc), .parity_error(parity_error)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected output for one byte position, from the requirements
    task automatic model(input int r, input int g, input int s, input logic [7:0] din,
                         input logic [3:0] cfg, output logic [7:0] e, output bit m,
                         output string tag);
        int idx;
        int sel;
        idx = r * 3 * NS + g * NS + s;
        e = din; m = 1'b0; tag = "R4"; sel = -1;
        if (g >= 3) tag = "R6";
        else if (r == 0 && g == 0) begin e = 8'hF6; tag = "R2"; end
        else if (r == 0 && g == 1) begin e = 8'h28; tag = "R2"; end
        else if (r == 1 && g == 0) begin e = 8'h00; m = (s == 0); tag = "R3"; end
        else if (r == 1) sel = 2;
        else if (r == 2 || r == 5 || r == 6 || r == 7) sel = 3;
        else if (r == 4 && g != 0) sel = 0;
        else if (r == 8) sel = (g == 2) ? 2 : 1;
        if (sel >= 0) begin
            tag = "R5 R7 R10";
            if (cfg[sel]) e = sb[idx];
        end
    endtask

    task automatic run_frame(input logic [3:0] cfg_a, input logic [3:0] cfg_b, input int nbytes);
        int cnt;
        bit have;
        logic [7:0] pe;
        bit pm;
        string ptag;
        cnt = 0; have = 1'b0; pe = '0; pm = 1'b0; ptag = "";
        for (int r = 0; r < 9; r++)
            for (int g = 0; g < GRPS; g++)
                for (int s = 0; s < NS; s++) begin
                    if (cnt < nbytes) begin
                        @(negedge clk);
                        if (have) begin
                            chk(pdata_out == pe, ptag, "byte", pdata_out, pe);
                            chk(b1_recalc == pm, "R3", "b1_recalc", b1_recalc, pm);
                        end
                        pdata_in    = 8'($urandom);
                        frame_start = (cnt == 0);
                        cfg_insert  = (cnt == 0) ? cfg_a : cfg_b;
                        model(r, g, s, pdata_in, cfg_a, pe, pm, ptag);
                        if (cnt == 0) ptag = "R1 R2";
                        have = 1'b1;
                        cnt++;
                    end
                end
        @(negedge clk);
        chk(pdata_out == pe, ptag, "last byte", pdata_out, pe);
        chk(b1_recalc == pm, "R3", "last b1_recalc", b1_recalc, pm);
        frame_start = 1'b0;
    endtask

    task automatic send_serial(input bit corrupt, input int nbytes);
        logic [7:0] b;
        bit acc;
        bit pbit;
        bit exp_err;
        acc = 1'b0;
        pbit = pv_valid ? (pv_par ^ corrupt) : 1'($urandom);
        exp_err = pv_valid && (pbit != pv_par);
        for (int i = 0; i < nbytes; i++) begin
            b = 8'($urandom);
            if (i == 0) b[7] = pbit;
            for (int k = 7; k >= 0; k--) begin
                @(negedge clk);
                if (i == 0 && k == 6)
                    chk(parity_error == exp_err, pv_valid ? "R8" : "R9", "parity pulse",
                        parity_error, exp_err);
                if (i == 0 && k == 5)
                    chk(parity_error == 1'b0, "R8", "pulse width", parity_error, 0);
                toh_sfs = (i == 0 && k == 7);
                toh_sdi = b[k];
                if (!(i == 0 && k == 7)) acc ^= b[k];
            end
            sb[i] = b;
        end
        @(negedge clk);
        toh_sfs = 1'b0;
        toh_sdi = 1'b0;
        pv_valid = (nbytes == TOHB);
        pv_par   = acc;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk(pdata_out == 8'h00, "R12", "reset pdata_out", pdata_out, 0);
        chk(b1_recalc == 1'b0, "R12", "reset b1_recalc", b1_recalc, 0);
        chk(parity_error == 1'b0, "R12", "reset parity_error", parity_error, 0);
        rst_n = 1'b1;

        // before any frame start: plain one-cycle pass-through
        for (int i = 0; i < 12; i++) begin
            logic [7:0] prev;
            @(negedge clk);
            prev = pdata_in;
            if (i > 0) begin
                chk(pdata_out == prev, "R11 R12", "unsynced pass", pdata_out, prev);
                chk(b1_recalc == 1'b0, "R11", "unsynced b1", b1_recalc, 0);
            end
            pdata_in = 8'($urandom);
        end

        send_serial(1'b0, TOHB);                  // first frame: no check (R9)
        run_frame(4'hF, 4'hF, 9 * GRPS * NS);     // all groups inserted (R5)
        run_frame(4'h0, 4'h0, 9 * GRPS * NS);     // all transparent
        send_serial(1'b0, TOHB);                  // good parity (R8)
        send_serial(1'b1, TOHB);                  // bad parity (R8)
        run_frame(4'h5, 4'hA, 9 * GRPS * NS);     // mid-frame change ignored (R10)
        run_frame(4'hA, 4'h5, 9 * GRPS * NS);
        send_serial(1'b0, 20);                    // truncated frame
        send_serial(1'b1, TOHB);                  // preceded by short frame: no check (R9)
        send_serial(1'b1, TOHB);                  // bad parity again (R8)
        run_frame(4'h3, 4'hC, 50);                // early restart (R1)
        run_frame(4'h9, 4'h6, 9 * GRPS * NS);

        for (int it = 0; it < 6; it++) begin
            send_serial(1'($urandom % 2), TOHB);
            run_frame(4'($urandom), 4'($urandom), (it == 3) ? 70 : 9 * GRPS * NS);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule